// File: doc/BRIEF.md
# Recentring Bit Elastic Buffer

This block is a one-bit-wide elastic store placed between a recovered receive clock and an unrelated local clock that takes data out. It absorbs two kinds of rate mismatch. The first is a periodic wander that averages to zero. The second is a steady offset between two free-running clocks, which eventually forces a slip. The programmed centre depth N is the nominal fill. The fill may wander anywhere from empty to 2N bits.

At reset the buffer starts with its fill preset to N, so the output side begins with a full centre's worth of delay. An overrun throws away the most recently written N bits. An underrun rewinds the read side by N so the most recent N bits are sent again. After either slip the fill is back at N and a sticky slip flag is raised. A write pointer and a read pointer each live in their own clock domain. They cross as Gray codes, and a re-centre is passed to the other domain as an offset value carried by a toggle handshake. The read (status) domain reports the fill in bits and as a signed percentage of N. The percentage is negated while the slip flag is set.

Top module: `elastic_bit_buffer`

## Requirements
- R1: After reset the reported fill equals the centre depth N, the percentage reads 100 and the slip flag is clear.
- R2: Each accepted write raises the fill by one and each read lowers it by one, as seen on the fill output once the pointer crossing has settled.
- R3: Bits leave in the order they were written, following the N preset bits present after reset.
- R4: A write arriving when the fill is 2N-1 causes an overrun. The N most recent bits, including that write, are discarded, the fill returns to N, and the next N reads return the N oldest stored bits.
- R5: A read taken when one bit remains causes an underrun. That read returns the bit, the fill then returns to N, and the next N reads replay the last N bits read.
- R6: Either slip sets the slip flag, which then stays set until a one-cycle clear pulse arrives. If a clear arrives in the same read cycle as a slip event, the flag stays set.
- R7: The percentage output equals floor(fill*100/N) as a signed 16-bit value, one read-clock cycle after the fill. It is negated while the slip flag is set (N=4 gives 25 per bit).
- R8: The write clock and the read clock are unrelated. Pointers cross as Gray codes changing at most one bit per clock, and a stream at unequal rates loses no bit and reorders none up to its first slip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered receive clock (write side) |
| rclk | input | 1 | Local output clock (read and status side) |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| center | input | AW | Centre depth N in bits, 4 to 2^(AW-1), static while running |
| wr_valid | input | 1 | Write strobe, one bit per wclk cycle |
| wr_bit | input | 1 | Data bit to store |
| rd_en | input | 1 | Read strobe, one bit per rclk cycle |
| rd_bit | output | 1 | Bit read, registered on the rclk edge that takes the read |
| slip_clr | input | 1 | Clears the slip flag (rclk domain) |
| slip | output | 1 | Sticky slip flag |
| fill | output | AW+1 | Current fill in bits as seen in the read domain |
| fill_pct | output | 16 | Signed fill percentage of N, negative while slipped |

## Verification
A read updates the fill on the same rclk edge. A write reaches the read side one wclk edge plus two to three rclk edges later, and an overrun's slip and re-centre need the handshake, which is about one wclk and three rclk edges. The percentage trails the fill by one more rclk edge. For these reasons every fill, percentage and slip check waits twelve read cycles after the last stimulus, while read data is sampled at the falling edge right after the edge that takes each read. The clear-against-slip race is driven in a single read cycle and checked at the next falling edge. In the streaming run only bits read before a slip shows on the flag are compared.

// File: rtl/elastic_bit_buffer.sv
module elastic_bit_buffer #(
  parameter int AW = 11
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic [AW-1:0]     center,
  input  logic              wr_valid,
  input  logic              wr_bit,
  input  logic              rd_en,
  output logic              rd_bit,
  input  logic              slip_clr,
  output logic              slip,
  output logic [AW:0]       fill,
  output logic signed [15:0] fill_pct
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int QW    = PW + 7;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic mem [DEPTH];

  logic [PW-1:0] n_ext, two_n;
  assign n_ext = PW'(center);
  assign two_n = n_ext << 1;

  // write domain state
  logic [PW-1:0] wraw, woff, woff_tx, roff_w, wgray, rg_s1, rg_s2;
  logic          w_req, wak_s1, wak_s2, r_ack, rrq_s1, rrq_s2;
  // read domain state
  logic [PW-1:0] rraw, roff, roff_tx, woff_r, rgray, wg_s1, wg_s2;
  logic          r_req, rak_s1, rak_s2, w_ack, wrq_s1, wrq_s2;

  logic [PW-1:0] w_eff, r_view, wfill;
  logic          ovr_evt;
  assign w_eff   = wraw - woff;
  assign r_view  = g2b(rg_s2) - roff_w - n_ext;
  assign wfill   = w_eff - r_view;
  assign ovr_evt = wr_valid && (wfill >= two_n - PW'(1));

  always_ff @(posedge wclk)
    if (wr_valid) mem[w_eff[AW-1:0]] <= wr_bit;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wraw <= '0; woff <= '0; woff_tx <= '0; roff_w <= '0;
      wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
      w_req <= 1'b0; wak_s1 <= 1'b0; wak_s2 <= 1'b0;
      r_ack <= 1'b0; rrq_s1 <= 1'b0; rrq_s2 <= 1'b0;
    end else begin
      wgray  <= b2g(wraw);
      rg_s1  <= rgray;
      rg_s2  <= rg_s1;
      wak_s1 <= w_ack;
      wak_s2 <= wak_s1;
      rrq_s1 <= r_req;
      rrq_s2 <= rrq_s1;
      if (wr_valid) begin
        wraw <= wraw + PW'(1);
        if (ovr_evt) woff <= woff + n_ext;
      end
      if (wak_s2 == w_req && woff_tx != woff) begin
        woff_tx <= woff;
        w_req   <= ~w_req;
      end
      if (rrq_s2 != r_ack) begin
        roff_w <= roff_tx;
        r_ack  <= rrq_s2;
      end
    end
  end

  logic [PW-1:0] w_view, r_eff, rfill;
  logic          und_evt, ovr_seen;
  assign w_view   = g2b(wg_s2) - woff_r;
  assign r_eff    = rraw - roff - n_ext;
  assign rfill    = w_view - r_eff;
  assign und_evt  = rd_en && (rfill <= PW'(1));
  assign ovr_seen = (wrq_s2 != w_ack);
  assign fill     = rfill;

  logic [QW-1:0] prod, quo;
  logic signed [15:0] pct_now;
  assign prod    = QW'(rfill) * QW'(100);
  assign quo     = (n_ext == '0) ? '0 : prod / QW'(n_ext);
  assign pct_now = 16'(quo);

  always_ff @(posedge rclk)
    if (rd_en) rd_bit <= mem[r_eff[AW-1:0]];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rraw <= '0; roff <= '0; roff_tx <= '0; woff_r <= '0;
      rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      r_req <= 1'b0; rak_s1 <= 1'b0; rak_s2 <= 1'b0;
      w_ack <= 1'b0; wrq_s1 <= 1'b0; wrq_s2 <= 1'b0;
      slip <= 1'b0; fill_pct <= '0;
    end else begin
      rgray  <= b2g(rraw);
      wg_s1  <= wgray;
      wg_s2  <= wg_s1;
      rak_s1 <= r_ack;
      rak_s2 <= rak_s1;
      wrq_s1 <= w_req;
      wrq_s2 <= wrq_s1;
      if (rd_en) begin
        rraw <= rraw + PW'(1);
        if (und_evt) roff <= roff + n_ext;
      end
      if (ovr_seen) begin
        woff_r <= woff_tx;
        w_ack  <= wrq_s2;
      end
      if (rak_s2 == r_req && roff_tx != roff) begin
        roff_tx <= roff;
        r_req   <= ~r_req;
      end
      if (und_evt || ovr_seen) slip <= 1'b1;
      else if (slip_clr)       slip <= 1'b0;
      fill_pct <= slip ? -pct_now : pct_now;
    end
  end

  p_wgray_step_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  p_rgray_step_r8: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  p_overrun_recentre_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    ovr_evt |=> wfill <= n_ext);
  p_underrun_flag_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    und_evt |=> slip);
  p_slip_hold_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    slip && !slip_clr |=> slip);
  p_slip_clear_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    slip_clr && !und_evt && !ovr_seen |=> !slip);
  p_pct_sign_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    slip && rfill != '0 |=> fill_pct < 0);
endmodule

// File: tb/elastic_bit_buffer_bench.sv
`timescale 1ns/100ps
module elastic_bit_buffer_bench;
  localparam int AW = 11;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] center = '0;
  logic wr_valid = 1'b0, wr_bit = 1'b0, rd_en = 1'b0, slip_clr = 1'b0;
  logic rd_bit, slip;
  logic [AW:0] fill;
  logic signed [15:0] fill_pct;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 rclk = ~rclk;
  always #2.6 wclk = ~wclk;

  elastic_bit_buffer #(.AW(AW)) u_elastic_bit_buffer (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .center(center),
    .wr_valid(wr_valid), .wr_bit(wr_bit), .rd_en(rd_en), .rd_bit(rd_bit),
    .slip_clr(slip_clr), .slip(slip), .fill(fill), .fill_pct(fill_pct));

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge rclk);
  endtask

  task automatic do_reset(int n);
    rst_n = 1'b0; wr_valid = 1'b0; rd_en = 1'b0; slip_clr = 1'b0;
    center = AW'(n);
    repeat (3) @(negedge rclk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic write_bits(int n, logic [63:0] pat);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_valid = 1'b1;
      wr_bit   = pat[i];
    end
    @(negedge wclk);
    wr_valid = 1'b0;
  endtask

  task automatic read_bits(int n, output logic [63:0] got);
    got = '0;
    @(negedge rclk);
    rd_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      got[i] = rd_bit;
      if (i == n - 1) rd_en = 1'b0;
    end
  endtask

  task automatic clear_pulse();
    @(negedge rclk) slip_clr = 1'b1;
    @(negedge rclk) slip_clr = 1'b0;
  endtask

  function automatic logic patb(int i);
    return logic'(((i * 7) ^ (i >> 3) ^ (i >> 5)) & 1);
  endfunction

  task automatic t_reset_state();
    do_reset(8);
    chk("R1", "fill after reset", int'(fill), 8);
    chk("R1", "pct after reset", int'(fill_pct), 100);
    chk("R1", "slip after reset", int'(slip), 0);
  endtask

  task automatic t_fill_and_pct();
    logic [63:0] g;
    do_reset(8);
    write_bits(4, 64'b1010);
    settle();
    chk("R2", "fill after 4 writes", int'(fill), 12);
    chk("R7", "pct at fill 12 of 8", int'(fill_pct), 150);
    read_bits(5, g);
    settle();
    chk("R2", "fill after 5 reads", int'(fill), 7);
    chk("R7", "pct at fill 7 of 8", int'(fill_pct), 87);
    do_reset(4);
    write_bits(1, 64'b1);
    settle();
    chk("R2", "fill N=4 after 1 write", int'(fill), 5);
    chk("R7", "pct at fill 5 of 4", int'(fill_pct), 125);
  endtask

  task automatic t_underrun_replay();
    logic [63:0] g;
    logic [7:0] e;
    e = 8'b0110_1101;
    do_reset(8);
    write_bits(4, 64'(e[3:0]));
    read_bits(8, g);
    settle();
    write_bits(4, 64'(e[7:4]));
    settle();
    chk("R2", "fill before drain", int'(fill), 8);
    chk("R6", "no slip before drain", int'(slip), 0);
    read_bits(16, g);
    chk("R3", "order of first pass", int'(g[7:0]), int'(e));
    chk("R5", "replayed bits", int'(g[15:8]), int'(e));
    settle();
    chk("R5", "fill after underrun", int'(fill), 8);
    chk("R6", "slip set by underrun", int'(slip), 1);
    chk("R7", "pct negated while slipped", int'(fill_pct), -100);
    clear_pulse();
    chk("R6", "slip cleared", int'(slip), 0);
    @(negedge rclk);
    chk("R7", "pct positive after clear", int'(fill_pct), 100);
  endtask

  task automatic t_clear_race();
    logic [63:0] g;
    do_reset(8);
    read_bits(8, g);
    settle();
    chk("R6", "slip from preset drain", int'(slip), 1);
    read_bits(7, g);
    settle();
    chk("R2", "fill down to one", int'(fill), 1);
    @(negedge rclk);
    rd_en = 1'b1; slip_clr = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0; slip_clr = 1'b0;
    chk("R6", "slip wins over clear", int'(slip), 1);
    settle();
    chk("R5", "fill after race underrun", int'(fill), 8);
    clear_pulse();
    chk("R6", "slip cleared after race", int'(slip), 0);
  endtask

  task automatic t_overrun_drop();
    logic [63:0] g;
    logic [6:0] a;
    logic [8:0] b;
    a = 7'b1011001;
    b = 9'b010010011;
    do_reset(8);
    write_bits(7, 64'(a));
    settle();
    read_bits(8, g);
    settle();
    chk("R6", "no slip before overrun", int'(slip), 0);
    write_bits(9, 64'(b));
    settle();
    chk("R4", "fill after overrun", int'(fill), 8);
    chk("R6", "slip set by overrun", int'(slip), 1);
    chk("R7", "pct after overrun", int'(fill_pct), -100);
    read_bits(8, g);
    chk("R4", "oldest bits kept", int'(g[7:0]), int'({b[0], a}));
  endtask

  task automatic t_stream();
    int cmp = 0, mis = 0;
    bit prev_slip = 0;
    bit saw_slip = 0;
    do_reset(64);
    fork
      begin
        for (int i = 0; i < 2600; i++) begin
          @(negedge wclk);
          wr_valid = 1'b1;
          wr_bit   = patb(i);
        end
        @(negedge wclk);
        wr_valid = 1'b0;
      end
      begin
        @(negedge rclk);
        rd_en = 1'b1;
        for (int j = 0; j < 2600; j++) begin
          @(negedge rclk);
          if (!prev_slip && j >= 64) begin
            cmp++;
            if (rd_bit !== patb(j - 64)) mis++;
          end
          prev_slip = prev_slip | slip;
          if (slip) saw_slip = 1;
        end
        rd_en = 1'b0;
      end
    join
    chk("R8", "stream mismatches before slip", mis, 0);
    chk("R8", "stream compared enough bits", int'(cmp > 1000), 1);
    chk("R5", "faster reader ends in slip", int'(saw_slip), 1);
  endtask

  initial begin
    t_reset_state();
    t_fill_and_pct();
    t_underrun_replay();
    t_clear_race();
    t_overrun_drop();
    t_stream();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule